// File: doc/BRIEF.md
# Dual-Ratio Performance Mode Sequencer

This block moves a processor core between a low-frequency and a high-frequency operating point. It never resets the core and never changes the bus clock frequency. Software raises a one-cycle request and names the mode it wants. If that mode is already in effect, nothing happens. Otherwise the sequencer asks for the bus clock to be stopped, which puts the core in deep sleep. While the core sleeps, it changes the supply level and the core-to-bus ratio select. It then releases the clock and waits for the core PLL to lock before it reports the new mode.

The order of the two changes depends on direction. Going up, the supply is raised first and the ratio select is switched afterwards. Going down, the ratio select is switched first and the supply is lowered afterwards. This way the core never runs a fast ratio on a low supply. Each supply change waits for an acknowledge from the regulator, and a timeout bounds that wait. If the acknowledge does not come in time, the sequencer sets an error flag, puts the supply and ratio select back to the mode it started from, releases the clock and finishes with the mode unchanged.

Top module: `perf_mode_seq`

## Requirements
- R1: After reset, modeHigh=0, vidHigh=0, ratioSelN=1, clkStopReq=0, busy=0 and errFlag=0. Whenever busy=0, vidHigh equals modeHigh and ratioSelN equals the inverse of modeHigh.
- R2: A request with modeTarget=1, made while modeHigh=0, produces these output changes in this order: clkStopReq rises, vidHigh rises, ratioSelN falls (0 selects the fast ratio), clkStopReq falls, then modeHigh rises.
- R3: A request with modeTarget=0, made while modeHigh=1, produces these output changes in this order: clkStopReq rises, ratioSelN rises, vidHigh falls, clkStopReq falls, then modeHigh falls.
- R4: The first supply or ratio change comes exactly SLEEP_CYCLES cycles after clkStopReq rises.
- R5: busy falls, and modeHigh takes its new value, exactly LOCK_CYCLES cycles after clkStopReq falls.
- R6: After a supply change, the sequence does not move on until pgAck is sampled high.
- R7: If pgAck stays low for PG_TIMEOUT cycles after a supply change, errFlag rises on that cycle. At the same time vidHigh and ratioSelN return to the values of the unchanged mode. The clock is then released, and busy later falls with modeHigh unchanged.
- R8: A request for the mode already in effect changes no output.
- R9: A request made while busy=1 is ignored.
- R10: errFlag stays set until the next accepted request, which clears it in the cycle that clkStopReq rises.
- R11: busy rises in the cycle after a request is accepted, together with clkStopReq, and stays high until the lock wait ends. clkStopReq is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeReq | input | 1 | One-cycle mode-change request |
| modeTarget | input | 1 | Requested mode: 1 selects high frequency |
| pgAck | input | 1 | Regulator acknowledge that the new supply level is good |
| clkStopReq | output | 1 | Request to stop the bus clock in its low level (deep sleep) |
| vidHigh | output | 1 | Supply level select: 1 selects the higher voltage |
| ratioSelN | output | 1 | Active-low ratio select: 0 selects the high-frequency ratio |
| busy | output | 1 | A transition is in progress |
| modeHigh | output | 1 | Current mode: 1 means high frequency |
| errFlag | output | 1 | The last transition was aborted on a regulator timeout |

## Verification
A wrong FSM state or a lost step would show at the ports as a supply or ratio change in the wrong order, or one made while the clock is running. It could also show as a change missing from the observed sequence, and each such change is compared against the expected order as soon as it happens. A wrong counter limit would shift the first change after the clock stop, the busy fall after the clock release, or the error rise after a supply change. Each of these offsets is measured to the exact cycle within one transition. A sequencer that does not wait for the acknowledge would switch the ratio or release the clock within a cycle or two of the supply change instead of after the regulator delay.

// File: rtl/mode_seq_pkg.sv
package mode_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SLEEP,
    S_VUP,
    S_RHI,
    S_RLO,
    S_VDN,
    S_ABORT,
    S_LOCK
  } seq_state_t;

  typedef struct packed {
    logic accept;
    logic raiseVid;
    logic lowerVid;
    logic selHi;
    logic selLo;
    logic restore;
    logic relClk;
    logic commit;
    logic cntClr;
  } seq_strobe_t;

endpackage

// File: rtl/mode_seq_ctrl.sv
module mode_seq_ctrl
  import mode_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeReq,
  input  logic        modeTarget,
  input  logic        pgAck,
  input  logic        modeHigh,
  input  logic        tgtHigh,
  input  logic        sleepDone,
  input  logic        pgExpired,
  input  logic        lockDone,
  output seq_strobe_t strobe,
  output logic        busy
);

  seq_state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        // same-mode requests fall through untouched (R8)
        if (modeReq && (modeTarget != modeHigh)) begin
          strobe.accept = 1'b1;
          nextState     = S_SLEEP;
        end
      end
      S_SLEEP: begin
        if (sleepDone) begin
          strobe.cntClr = 1'b1;
          if (tgtHigh) begin
            strobe.raiseVid = 1'b1;
            nextState       = S_VUP;
          end else begin
            strobe.selLo = 1'b1;
            nextState    = S_RLO;
          end
        end
      end
      S_VUP: begin
        if (pgAck) begin
          strobe.selHi = 1'b1;
          nextState    = S_RHI;
        end else if (pgExpired) begin
          strobe.restore = 1'b1;
          nextState      = S_ABORT;
        end
      end
      S_RHI: begin
        strobe.relClk = 1'b1;
        nextState     = S_LOCK;
      end
      S_RLO: begin
        strobe.lowerVid = 1'b1;
        strobe.cntClr   = 1'b1;
        nextState       = S_VDN;
      end
      S_VDN: begin
        if (pgAck) begin
          strobe.relClk = 1'b1;
          nextState     = S_LOCK;
        end else if (pgExpired) begin
          strobe.restore = 1'b1;
          nextState      = S_ABORT;
        end
      end
      S_ABORT: begin
        strobe.relClk = 1'b1;
        nextState     = S_LOCK;
      end
      S_LOCK: begin
        if (lockDone) begin
          strobe.commit = 1'b1;
          nextState     = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/mode_seq_dp.sv
module mode_seq_dp
  import mode_seq_pkg::*;
#(
  parameter int SLEEP_CYCLES = 4,
  parameter int PG_TIMEOUT   = 2000,
  parameter int LOCK_CYCLES  = 7500
) (
  input  logic        clk,
  input  logic        rstN,
  input  seq_strobe_t strobe,
  input  logic        modeTarget,
  output logic        clkStopReq,
  output logic        vidHigh,
  output logic        ratioSelN,
  output logic        modeHigh,
  output logic        tgtHigh,
  output logic        errFlag,
  output logic        sleepDone,
  output logic        pgExpired,
  output logic        lockDone
);

  localparam int MAX_AB  = (SLEEP_CYCLES > PG_TIMEOUT) ? SLEEP_CYCLES : PG_TIMEOUT;
  localparam int CNT_TOP = (MAX_AB > LOCK_CYCLES) ? MAX_AB : LOCK_CYCLES;
  localparam int CW      = $clog2(CNT_TOP + 1);
  localparam logic [CW-1:0] SLEEP_LAST = CW'(SLEEP_CYCLES - 1);
  localparam logic [CW-1:0] PG_LAST    = CW'(PG_TIMEOUT - 1);
  localparam logic [CW-1:0] LOCK_LAST  = CW'(LOCK_CYCLES - 1);
  localparam logic [CW-1:0] CNT_SAT    = CW'(CNT_TOP);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.accept || strobe.cntClr || strobe.relClk) begin
      cnt <= '0;
    end else if (cnt != CNT_SAT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sleepDone = (cnt == SLEEP_LAST);
  assign pgExpired = (cnt == PG_LAST);
  assign lockDone  = (cnt == LOCK_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkStopReq <= 1'b0;
      vidHigh    <= 1'b0;
      ratioSelN  <= 1'b1;
      modeHigh   <= 1'b0;
      tgtHigh    <= 1'b0;
      errFlag    <= 1'b0;
    end else begin
      if (strobe.accept) begin
        tgtHigh    <= modeTarget;
        clkStopReq <= 1'b1;
        errFlag    <= 1'b0;
      end
      if (strobe.raiseVid) vidHigh   <= 1'b1;
      if (strobe.lowerVid) vidHigh   <= 1'b0;
      if (strobe.selHi)    ratioSelN <= 1'b0;
      if (strobe.selLo)    ratioSelN <= 1'b1;
      if (strobe.restore) begin
        vidHigh   <= modeHigh;
        ratioSelN <= ~modeHigh;
        tgtHigh   <= modeHigh;
        errFlag   <= 1'b1;
      end
      if (strobe.relClk) clkStopReq <= 1'b0;
      if (strobe.commit) modeHigh   <= tgtHigh;
    end
  end

  // R2: ratio select moves only while the clock has been held stopped
  p_sel_only_stopped_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ratioSelN) |-> (clkStopReq && $past(clkStopReq)));

  // R6: supply select moves only while the clock has been held stopped
  p_vid_only_stopped_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vidHigh) |-> (clkStopReq && $past(clkStopReq)));

  // R2: fast ratio is never selected on the low supply
  p_up_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ratioSelN) |-> vidHigh);

  // R3: supply is lowered only once the slow ratio is selected
  p_down_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vidHigh) |-> ratioSelN);

  // R7: an abort happens while the core is still in deep sleep
  p_err_in_sleep_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> clkStopReq);

endmodule

// File: rtl/perf_mode_seq.sv
module perf_mode_seq
  import mode_seq_pkg::*;
#(
  parameter int SLEEP_CYCLES = 4,
  parameter int PG_TIMEOUT   = 2000,
  parameter int LOCK_CYCLES  = 7500
) (
  input  logic clk,
  input  logic rstN,
  input  logic modeReq,
  input  logic modeTarget,
  input  logic pgAck,
  output logic clkStopReq,
  output logic vidHigh,
  output logic ratioSelN,
  output logic busy,
  output logic modeHigh,
  output logic errFlag
);

  seq_strobe_t strobe;
  logic tgtHigh, sleepDone, pgExpired, lockDone;

  mode_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeReq    (modeReq),
    .modeTarget (modeTarget),
    .pgAck      (pgAck),
    .modeHigh   (modeHigh),
    .tgtHigh    (tgtHigh),
    .sleepDone  (sleepDone),
    .pgExpired  (pgExpired),
    .lockDone   (lockDone),
    .strobe     (strobe),
    .busy       (busy)
  );

  mode_seq_dp #(
    .SLEEP_CYCLES (SLEEP_CYCLES),
    .PG_TIMEOUT   (PG_TIMEOUT),
    .LOCK_CYCLES  (LOCK_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .modeTarget (modeTarget),
    .clkStopReq (clkStopReq),
    .vidHigh    (vidHigh),
    .ratioSelN  (ratioSelN),
    .modeHigh   (modeHigh),
    .tgtHigh    (tgtHigh),
    .errFlag    (errFlag),
    .sleepDone  (sleepDone),
    .pgExpired  (pgExpired),
    .lockDone   (lockDone)
  );

  // R11: clock stop is only requested inside a transition
  p_stop_needs_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    clkStopReq |-> busy);

  // R5: the reported mode changes only as the transition ends
  p_mode_at_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeHigh) |-> $fell(busy));

  // R1: at rest, supply and ratio agree with the reported mode
  p_idle_consistent_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ((vidHigh == modeHigh) && (ratioSelN == !modeHigh)));

endmodule

// File: tb/tb_perf_mode_seq.sv
`timescale 1ns/1ps
module tb_perf_mode_seq;

  localparam int SLEEP  = 4;
  localparam int PGT    = 20;
  localparam int LOCK   = 40;
  localparam int PG_DLY = 6;

  localparam int K_BUSY = 0;
  localparam int K_STOP = 1;
  localparam int K_ERR  = 2;
  localparam int K_VID  = 3;
  localparam int K_SEL  = 4;
  localparam int K_MODE = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeReq = 1'b0;
  logic modeTarget = 1'b0;
  logic pgAck = 1'b1;
  logic clkStopReq, vidHigh, ratioSelN, busy, modeHigh, errFlag;

  always #2 clk = ~clk;

  perf_mode_seq #(
    .SLEEP_CYCLES (SLEEP),
    .PG_TIMEOUT   (PGT),
    .LOCK_CYCLES  (LOCK)
  ) dut (
    .clk        (clk),
    .rstN       (rstN),
    .modeReq    (modeReq),
    .modeTarget (modeTarget),
    .pgAck      (pgAck),
    .clkStopReq (clkStopReq),
    .vidHigh    (vidHigh),
    .ratioSelN  (ratioSelN),
    .busy       (busy),
    .modeHigh   (modeHigh),
    .errFlag    (errFlag)
  );

  typedef struct {
    int    kind;
    bit    val;
    string tag;
  } ev_t;

  ev_t expQ[$];
  int  checks = 0;
  int  failures = 0;
  int  cyc = 0;
  int  stopRiseCyc = 0;
  int  stopFallCyc = 0;
  int  lastVidCyc = 0;
  bit  dwellPending = 0;
  bit  eMode = 0;
  bit  eErr = 0;
  bit  regOk = 1;
  int  regCnt = 0;
  logic prevVidR = 1'b0;
  logic pBusy, pStop, pErr, pVid, pSel, pMode;

  task automatic chk(input bit cond, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void push(input int k, input bit v, input string t);
    ev_t e;
    e.kind = k;
    e.val  = v;
    e.tag  = t;
    expQ.push_back(e);
  endfunction

  task automatic seeEvent(input int k, input bit v);
    ev_t e;
    if (expQ.size() == 0) begin
      chk(1'b0, "R9", "unexpected output change (kind*10+value)", k * 10 + int'(v), -1);
    end else begin
      e = expQ.pop_front();
      chk((e.kind == k) && (e.val == v), e.tag, "output change (kind*10+value)",
          k * 10 + int'(v), e.kind * 10 + int'(e.val));
    end
  endtask

  // regulator model: acknowledge drops on a supply change, returns after PG_DLY
  always @(negedge clk) begin
    if (vidHigh !== prevVidR) begin
      pgAck    = 1'b0;
      regCnt   = 0;
      prevVidR = vidHigh;
    end else if (regCnt < PG_DLY) begin
      regCnt++;
    end else if (regOk) begin
      pgAck = 1'b1;
    end
  end

  // monitor: compare every output change against the scoreboard queue
  always @(negedge clk) begin
    if (!rstN) begin
      cyc = 0;
    end else begin
      cyc++;
      if (busy !== pBusy) begin
        seeEvent(K_BUSY, busy);
        if (!busy) chk(cyc - stopFallCyc == LOCK, "R5", "lock wait length", cyc - stopFallCyc, LOCK);
      end
      if (clkStopReq !== pStop) begin
        seeEvent(K_STOP, clkStopReq);
        if (clkStopReq) begin
          stopRiseCyc  = cyc;
          dwellPending = 1;
        end else begin
          stopFallCyc = cyc;
          if (!errFlag) chk(cyc - lastVidCyc > PG_DLY, "R6", "release before ack", cyc - lastVidCyc, PG_DLY + 1);
        end
      end
      if (errFlag !== pErr) begin
        seeEvent(K_ERR, errFlag);
        if (errFlag) chk(cyc - lastVidCyc == PGT, "R7", "timeout length", cyc - lastVidCyc, PGT);
      end
      if (vidHigh !== pVid) begin
        seeEvent(K_VID, vidHigh);
        if (dwellPending) begin
          chk(cyc - stopRiseCyc == SLEEP, "R4", "sleep dwell", cyc - stopRiseCyc, SLEEP);
          dwellPending = 0;
        end
        lastVidCyc = cyc;
      end
      if (ratioSelN !== pSel) begin
        seeEvent(K_SEL, ratioSelN);
        if (dwellPending) begin
          chk(cyc - stopRiseCyc == SLEEP, "R4", "sleep dwell", cyc - stopRiseCyc, SLEEP);
          dwellPending = 0;
        end
        if (!ratioSelN && !errFlag)
          chk(cyc - lastVidCyc > PG_DLY, "R6", "ratio switch before ack", cyc - lastVidCyc, PG_DLY + 1);
      end
      if (modeHigh !== pMode) seeEvent(K_MODE, modeHigh);
    end
    pBusy = busy;
    pStop = clkStopReq;
    pErr  = errFlag;
    pVid  = vidHigh;
    pSel  = ratioSelN;
    pMode = modeHigh;
  end

  // driver: push the expected change sequence, then issue the request
  task automatic doReq(input bit tgt, input bit ok, input bit late, input string tag);
    bit moving;
    moving = (tgt != eMode);
    if (moving) begin
      push(K_BUSY, 1'b1, "R11");
      push(K_STOP, 1'b1, tag);
      if (eErr) push(K_ERR, 1'b0, "R10");
      if (tgt) begin
        push(K_VID, 1'b1, "R2");
        if (ok) begin
          push(K_SEL, 1'b0, "R2");
        end else begin
          push(K_ERR, 1'b1, "R7");
          push(K_VID, 1'b0, "R7");
        end
      end else begin
        push(K_SEL, 1'b1, "R3");
        push(K_VID, 1'b0, "R3");
        if (!ok) begin
          push(K_ERR, 1'b1, "R7");
          push(K_VID, 1'b1, "R7");
          push(K_SEL, 1'b0, "R7");
        end
      end
      push(K_STOP, 1'b0, tag);
      push(K_BUSY, 1'b0, "R11");
      if (ok) push(K_MODE, tgt, tag);
      eErr = !ok;
      if (ok) eMode = tgt;
    end
    regOk = ok;
    @(negedge clk);
    modeReq    = 1'b1;
    modeTarget = tgt;
    @(negedge clk);
    modeReq = 1'b0;
    if (moving) begin
      chk(busy == 1'b1, "R11", "busy after accept", int'(busy), 1);
      if (late) begin
        repeat (8) @(negedge clk);
        modeReq    = 1'b1;
        modeTarget = !tgt;
        @(negedge clk);
        modeReq = 1'b0;
      end
      for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
    end else begin
      chk(busy == 1'b0, "R8", "busy on same-mode request", int'(busy), 0);
    end
    repeat (6) @(negedge clk);
    chk(expQ.size() == 0, tag, "pending expected changes", expQ.size(), 0);
    chk(modeHigh == eMode, late ? "R9" : tag, "final mode", int'(modeHigh), int'(eMode));
    chk(errFlag == eErr, ok ? "R10" : "R7", "final error flag", int'(errFlag), int'(eErr));
    regOk = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(modeHigh == 1'b0 && vidHigh == 1'b0, "R1", "reset mode/vid", {modeHigh, vidHigh}, 0);
    chk(ratioSelN == 1'b1, "R1", "reset ratio select", int'(ratioSelN), 1);
    chk(clkStopReq == 1'b0 && busy == 1'b0 && errFlag == 1'b0, "R1", "reset stop/busy/err",
        {clkStopReq, busy, errFlag}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && ratioSelN == 1'b1, "R1", "idle after reset", {busy, ratioSelN}, 1);

    doReq(1'b1, 1'b1, 1'b0, "R2");
    doReq(1'b1, 1'b1, 1'b0, "R8");
    doReq(1'b0, 1'b1, 1'b0, "R3");
    doReq(1'b0, 1'b1, 1'b0, "R8");
    doReq(1'b1, 1'b1, 1'b1, "R9");
    doReq(1'b0, 1'b1, 1'b1, "R9");
    doReq(1'b1, 1'b0, 1'b0, "R7");
    doReq(1'b1, 1'b1, 1'b0, "R10");
    doReq(1'b0, 1'b0, 1'b0, "R7");
    doReq(1'b0, 1'b1, 1'b0, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule